// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives a stereo serial audio stream carried on three wires: a bit clock, a channel-select level and a data line. All three come from another clock domain and are brought into the system clock domain by a two-flop synchroniser. The bit clock's rising edges are then detected there, and each one samples the data and channel-select lines. A bit counter tracks the position inside each channel half. The block then assembles left and right samples of up to 20 bits and presents each completed stereo pair on two parallel buses with a single-cycle valid strobe.

Five framings are supported, chosen by a 3-bit format input. Two are leading-aligned: the standard inter-IC sound framing, whose first data bit follows the channel-select change by one bit clock, and a left-justified framing, whose first data bit coincides with the change. Three are trailing-aligned (right-justified), with 16, 18 or 20 bit words ending at the next channel-select change. Words shorter than 20 bits come out left-aligned with zeros below them.

Top module: `serial_audio_rx`

## Requirements
- R1: During and directly after reset, `pcm_valid` is 0 and `pcm_left` and `pcm_right` are all zeros.
- R2: `fmt_sel` encodings: 3'b000 standard (first data bit on the second bit-clock rising edge after a channel-select change), 3'b100 left-justified (first data bit on the first rising edge), 3'b001 / 3'b010 / 3'b011 right-justified 16 / 18 / 20 bits. The unused codes 3'b101, 3'b110 and 3'b111 decode as 3'b000.
- R3: Channel select low marks a left word and high marks a right word. A pair is emitted only when a right word completes after a stored left word. A word completes at the first bit-clock rising edge that sees the opposite channel-select level.
- R4: `pcm_valid` is high for exactly one system clock per pair, and `pcm_left` and `pcm_right` change only in that cycle.
- R5: In the leading-aligned formats, a word of L bits appears as its L bits in the top of the 20-bit output with zeros below when L < 20. When L > 20, only the first 20 bits are kept and the rest are ignored.
- R6: In a right-justified format of N bits, the output is the last N bits sampled before the channel-select change, left-aligned with zeros below. Earlier bits in the half are ignored whatever their values.
- R7: Data and channel select are taken on the bit clock's rising edge after two-flop synchronisation. Halves of up to 32 bit clocks are handled, and the bit count saturates instead of wrapping.
- R8: The channel half in progress when the block leaves reset is discarded. After reset, the first pair emitted is the first complete left word followed by the first complete right word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_in | input | 1 | Serial bit clock, asynchronous to clk |
| chan_sel_in | input | 1 | Channel select level, changes on bit clock falling edges |
| ser_data_in | input | 1 | Serial data, MSB first |
| fmt_sel | input | 3 | Framing code, see R2 |
| pcm_left | output | 20 | Left sample of the last pair, left-aligned |
| pcm_right | output | 20 | Right sample of the last pair, left-aligned |
| pcm_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The bench sweeps every framing code across several half-frame lengths and word lengths, including words longer and shorter than 20 bits. It fills the unused part of each right-justified half with a non-zero pattern. An off-by-one in the standard framing's one-bit delay would shift every sample by a factor of two. A tail taken from the wrong shift-register slice would pull leading junk bits into the low end. If the partial first half after reset were not discarded, or the channels swapped, the bench would see one extra pair or a left/right mismatch. Each run also counts pairs against frames sent, so a missing or duplicated strobe shows up even when the data is correct.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    localparam int SAMPLE_W = 20;
    localparam int MAX_HALF = 32;
    localparam int SYNC_DEPTH = 2;

    typedef struct packed {
        logic       trailing;
        logic       lead_off;
        logic [4:0] tail_len;
    } fmt_cfg_t;

    function automatic fmt_cfg_t decode_fmt(input logic [2:0] code);
        fmt_cfg_t c;
        c.trailing = 1'b0;
        c.lead_off = 1'b1;
        c.tail_len = 5'd20;
        case (code)
            3'b001: begin c.trailing = 1'b1; c.tail_len = 5'd16; end
            3'b010: begin c.trailing = 1'b1; c.tail_len = 5'd18; end
            3'b011: begin c.trailing = 1'b1; c.tail_len = 5'd20; end
            3'b100: c.lead_off = 1'b0;
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sarx_capture.sv
module sarx_capture
    import sarx_pkg::*;
#(
    parameter int W        = SAMPLE_W,
    parameter int HALF_MAX = MAX_HALF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sck_s,
    input  logic         ws_s,
    input  logic         sd_s,
    input  logic [2:0]   fmt_sel,
    output logic         word_done,
    output logic         word_chan,
    output logic [W-1:0] word_data
);
    localparam int CNT_W = $clog2(HALF_MAX) + 1;
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    function automatic logic [W-1:0] put_lead(input logic [W-1:0] cur, input logic b,
                                             input logic [CNT_W-1:0] idx, input logic off);
        logic [W-1:0] r;
        int pos;
        r   = cur;
        pos = int'(idx) - int'(off);
        if (pos >= 0 && pos < W) r[W-1-pos] = b;
        return r;
    endfunction

    function automatic logic [W-1:0] take_tail(input logic [W-1:0] hist, input logic [4:0] len);
        return hist << (W - int'(len));
    endfunction

    fmt_cfg_t         cfg;
    logic             sck_prev, ws_prev, have_prev, armed;
    logic             rise, ws_flip;
    logic [CNT_W-1:0] bit_cnt;
    logic [W-1:0]     hist, lead;

    always_comb begin
        cfg     = decode_fmt(fmt_sel);
        rise    = sck_s & ~sck_prev;
        ws_flip = have_prev & (ws_s != ws_prev);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev  <= 1'b0;
            ws_prev   <= 1'b0;
            have_prev <= 1'b0;
            armed     <= 1'b0;
            bit_cnt   <= '0;
            hist      <= '0;
            lead      <= '0;
            word_done <= 1'b0;
            word_chan <= 1'b0;
            word_data <= '0;
        end else begin
            sck_prev  <= sck_s;
            word_done <= 1'b0;
            if (rise) begin
                hist      <= {hist[W-2:0], sd_s};
                ws_prev   <= ws_s;
                have_prev <= 1'b1;
                if (ws_flip) begin
                    armed <= 1'b1;
                    if (armed) begin
                        word_done <= 1'b1;
                        word_chan <= ws_prev;
                        word_data <= cfg.trailing ? take_tail(hist, cfg.tail_len) : lead;
                    end
                    bit_cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
                    lead    <= put_lead('0, sd_s, '0, cfg.lead_off);
                end else begin
                    if (bit_cnt != CNT_TOP) bit_cnt <= bit_cnt + 1'b1;
                    lead <= put_lead(lead, sd_s, bit_cnt, cfg.lead_off);
                end
            end
        end
    end

    // R7
    done_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        word_done |=> !word_done);

    // R8
    armed_first_chk: assert property (@(posedge clk) disable iff (rst)
        word_done |-> $past(armed));
endmodule

// File: rtl/sarx_pair.sv
module sarx_pair #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         word_done,
    input  logic         word_chan,
    input  logic [W-1:0] word_data,
    output logic [W-1:0] pcm_left,
    output logic [W-1:0] pcm_right,
    output logic         pcm_valid
);
    logic [W-1:0] left_hold;
    logic         left_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold <= '0;
            left_ok   <= 1'b0;
            pcm_left  <= '0;
            pcm_right <= '0;
            pcm_valid <= 1'b0;
        end else begin
            pcm_valid <= 1'b0;
            if (word_done) begin
                if (!word_chan) begin
                    left_hold <= word_data;
                    left_ok   <= 1'b1;
                end else if (left_ok) begin
                    pcm_left  <= left_hold;
                    pcm_right <= word_data;
                    pcm_valid <= 1'b1;
                    left_ok   <= 1'b0;
                end
            end
        end
    end

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |=> !pcm_valid);

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pcm_valid |-> ($stable(pcm_left) && $stable(pcm_right)));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_clk_in,
    input  logic                chan_sel_in,
    input  logic                ser_data_in,
    input  logic [2:0]          fmt_sel,
    output logic [SAMPLE_W-1:0] pcm_left,
    output logic [SAMPLE_W-1:0] pcm_right,
    output logic                pcm_valid
);
    logic [2:0]          synced;
    logic                word_done, word_chan;
    logic [SAMPLE_W-1:0] word_data;

    sarx_sync #(.N(3), .STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ser_data_in, chan_sel_in, ser_clk_in}),
        .dout (synced)
    );

    sarx_capture #(.W(SAMPLE_W), .HALF_MAX(MAX_HALF)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .sck_s     (synced[0]),
        .ws_s      (synced[1]),
        .sd_s      (synced[2]),
        .fmt_sel   (fmt_sel),
        .word_done (word_done),
        .word_chan (word_chan),
        .word_data (word_data)
    );

    sarx_pair #(.W(SAMPLE_W)) u_pair (
        .clk       (clk),
        .rst       (rst),
        .word_done (word_done),
        .word_chan (word_chan),
        .word_data (word_data),
        .pcm_left  (pcm_left),
        .pcm_right (pcm_right),
        .pcm_valid (pcm_valid)
    );

    // R3
    pair_order_chk: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> ($past(word_done) && $past(word_chan)));
endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        ws  = 1'b1;
    logic        sd  = 1'b0;
    logic [2:0]  fmt = 3'b000;
    logic [19:0] pcm_left, pcm_right;
    logic        pcm_valid;

    int checks = 0;
    int errors = 0;
    logic [19:0] exp_l [0:63];
    logic [19:0] exp_r [0:63];
    int n_exp = 0;
    int n_got = 0;
    logic valid_prev = 1'b0;

    always #4 clk = ~clk;

    serial_audio_rx u_dut (
        .clk(clk), .rst(rst), .ser_clk_in(sck), .chan_sel_in(ws), .ser_data_in(sd),
        .fmt_sel(fmt), .pcm_left(pcm_left), .pcm_right(pcm_right), .pcm_valid(pcm_valid)
    );

    function automatic logic [19:0] exp_word(input logic [23:0] w, input int len);
        logic [43:0] t;
        t = {20'd0, w};
        if (len >= 20) t = t >> (len - 20);
        else           t = t << (20 - len);
        return t[19:0];
    endfunction

    function automatic logic src_bit(input logic [2:0] f, input int b, input int len,
                                     input logic [23:0] w, input int k, input int salt);
        case (f)
            3'b001, 3'b010, 3'b011:
                if (k >= b - len) return w[len-1-(k-(b-len))];
                else              return (((k * 7 + salt) % 3) != 2);
            3'b100:
                if (k < len) return w[len-1-k];
                else         return 1'b0;
            default:
                if (k >= 1 && k - 1 < len) return w[len-k];
                else                       return 1'b0;
        endcase
    endfunction

    task automatic slot(input logic lvl, input logic d);
        sck = 1'b0;
        ws  = lvl;
        sd  = d;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic half(input logic lvl, input int b, input int len, input logic [23:0] w, input int salt);
        for (int k = 0; k < b; k++) slot(lvl, src_bit(fmt, b, len, w, k, salt));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sck = 1'b0;
        ws  = 1'b1;
        sd  = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        n_exp = 0;
        n_got = 0;
        @(negedge clk);
        checks++;
        if (pcm_valid !== 1'b0 || pcm_left !== 20'd0 || pcm_right !== 20'd0) begin
            errors++;
            $display("FAIL R1 reset state: valid=%b left=%h right=%h expected 0 00000 00000",
                     pcm_valid, pcm_left, pcm_right);
        end
    endtask

    // R2 R5 R6 R8: one sweep point, several frames after a partial half.
    task automatic run_cfg(input logic [2:0] f, input int b, input int len, input int frames, input int seed);
        logic [23:0] wl, wr, mask;
        fmt = f;
        do_reset();
        half(1'b1, 3, 3, 24'h7, seed);
        mask = (24'd1 << len) - 24'd1;
        for (int i = 0; i < frames; i++) begin
            wl = (24'(i * 24'h3A5C7 + seed * 24'h1B3 + 24'h91) ^ 24'hA5A5A5) & mask;
            wr = (24'(i * 24'h52F1D + seed * 24'h2C9 + 24'h47) ^ 24'h5A3C96) & mask;
            exp_l[n_exp] = exp_word(wl, len);
            exp_r[n_exp] = exp_word(wr, len);
            n_exp++;
            half(1'b0, b, len, wl, seed + i);
            half(1'b1, b, len, wr, seed + i + 1);
        end
        slot(1'b0, 1'b0);
        slot(1'b0, 1'b0);
        repeat (20) @(negedge clk);
        checks++;
        if (n_got != n_exp) begin
            errors++;
            $display("FAIL R8 R3 fmt=%b pair count actual %0d expected %0d", f, n_got, n_exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (pcm_valid) begin
                checks++;
                if (valid_prev) begin
                    errors++;
                    $display("FAIL R4 valid high two cycles: actual 1 expected 0");
                end
                checks++;
                if (n_got >= n_exp) begin
                    errors++;
                    $display("FAIL R8 unexpected pair: actual %h/%h expected none", pcm_left, pcm_right);
                end else if (pcm_left !== exp_l[n_got] || pcm_right !== exp_r[n_got]) begin
                    errors++;
                    $display("FAIL R2 R3 R5 R6 R7 fmt=%b pair %0d: actual %h/%h expected %h/%h",
                             fmt, n_got, pcm_left, pcm_right, exp_l[n_got], exp_r[n_got]);
                end
                n_got++;
            end
            valid_prev = pcm_valid;
        end else begin
            valid_prev = 1'b0;
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R2 R5: standard framing, shorter, exact and longer words
        run_cfg(3'b000, 32, 16, 3, 1);
        run_cfg(3'b000, 32, 20, 3, 2);
        run_cfg(3'b000, 32, 24, 3, 3);
        run_cfg(3'b000, 24, 20, 3, 4);
        // R2 R5: left-justified framing
        run_cfg(3'b100, 32, 16, 3, 5);
        run_cfg(3'b100, 32, 24, 3, 6);
        run_cfg(3'b100, 20, 20, 3, 7);
        // R6 R7: right-justified, tight and loose halves up to 32 bit clocks
        run_cfg(3'b001, 16, 16, 3, 8);
        run_cfg(3'b001, 32, 16, 3, 9);
        run_cfg(3'b010, 24, 18, 3, 10);
        run_cfg(3'b011, 20, 20, 3, 11);
        run_cfg(3'b011, 32, 20, 3, 12);
        // R2: unused codes fall back to standard framing
        run_cfg(3'b111, 32, 20, 2, 13);
        run_cfg(3'b101, 24, 18, 2, 14);
        finish_run();
    end
endmodule